// File: doc/BRIEF.md
# Set-Associative Tag and Permission Directory

This block keeps the bookkeeping of a set-associative cache without its data. Each way of each set holds a line tag, a two-bit permission state and a lock-owner context. One request per cycle comes in on a single port. An opcode selects the operation:

- an access check by request kind
- a presence test or an availability test
- allocation or deallocation
- a permission change
- lock set, clear or test
- a victim probe

Every request is answered one cycle later with a single-cycle response pulse.

Replacement is least-recently-used per set. A successful allocation, and any access whose tag matches, makes that way the most recent one. This holds even when the permission refuses the access. A probe of a full set names the least recently used way and returns the full line address stored there. A coherence controller can then evict that line before it allocates.

Top module: `tag_dir`

## Requirements
- R1: Sets number CACHE_BYTES / WAYS / LINE_BYTES, which must be greater than 1. The set index is req_addr_i[OFF_W +: IDX_W], where OFF_W = log2(LINE_BYTES) and IDX_W = log2(sets). The tag is the address bits above the index. Requests carry line-aligned addresses with the offset bits at zero. Lines in different sets never interact.
- R2: A request accepted with req_valid_i in cycle n gives rsp_valid_o high in cycle n+1 only. rsp_way_o and rsp_addr_o read 0 whenever the operation defines no value for them.
- R3: Permission codes are 0 not-present, 1 invalid, 2 read-only and 3 read-write. A tag matches only when its way is not in state 0. The presence test (opcode 1) returns ok=1 and the matching way on a match, and ok=0 otherwise.
- R4: The access check (opcode 0) uses the request kind: 0 load, 1 instruction fetch, 2 store, with 3 treated as a store. It returns ok=1 when the matching line is read-write, or when the line is read-only and the kind is load or fetch. All other cases, including a store to a read-only line, return ok=0. On any match the matching way is reported.
- R5: The availability test (opcode 2) returns ok=1 when the address already matches in its set or any way of the set is in state 0.
- R6: A successful allocation (opcode 3) takes the lowest-numbered way in state 0. It writes the tag, sets state 1, unlocks the way, makes it most recent and reports it on rsp_way_o.
- R7: Allocating an address that already matches, or allocating into a set with no way in state 0, returns err=1 and changes nothing.
- R8: Deallocation (opcode 4) puts the matching way in state 0 and unlocks it. Opcodes 4 to 8 aimed at an address with no match return err=1 and change nothing.
- R9: A lock value of all ones means unlocked. Lock (opcode 6) stores req_ctx_i and unlock (opcode 7) stores all ones. The lock test (opcode 8) returns ok=1 only when the stored value equals req_ctx_i.
- R10: A permission change (opcode 5) writes req_perm_i to the matching way. Any new state other than read-write also unlocks the way.
- R11: Allocation and any access check with a tag match make that way most recent. The victim of a set is its least recently used way. After reset, way 0 is the oldest and the highest way the newest.
- R12: The probe (opcode 9) on a set that fails the availability test returns ok=1, the victim way, and the victim line address built from its tag and the set index with zero offset. Otherwise it returns err=1.
- R13: After reset all ways are in state 0 and every lock reads all ones.
- R14: Opcodes 10 to 15 return err=1 and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 4 | Operation code |
| req_addr_i | input | ADDR_W | Line-aligned request address |
| req_kind_i | input | 2 | Access kind for the access check |
| req_perm_i | input | 2 | New permission for a permission change |
| req_ctx_i | input | CTX_W | Context for lock and lock test |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_ok_o | output | 1 | Boolean result |
| rsp_err_o | output | 1 | Illegal request, state left unchanged |
| rsp_way_o | output | log2(WAYS) | Matching, allocated or victim way |
| rsp_addr_o | output | ADDR_W | Victim line address from a probe |

## Verification
The assertions check several things on every cycle:
- a request matches at most one way;
- each set has exactly one least-recent way;
- addresses are line aligned;
- a granted allocation leaves the way invalid and unlocked;
- a refused allocation leaves the arrays untouched;
- a permission change to anything but read-write unlocks the way.

Other behaviours need the bench's request sequences to show up:
- the permission-by-kind hit rules;
- the exact LRU order after mixed hits, denied hits and allocations;
- the probe's reconstructed address;
- the lock rules across deallocation and reallocation.

A directed sequence and a long random one over a small address pool are compared with a behavioural model after every request.

// File: rtl/tag_dir_pkg.sv
package tag_dir_pkg;
  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_INV  = 2'd1,
    PERM_RO   = 2'd2,
    PERM_RW   = 2'd3
  } perm_e;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_FETCH = 2'd1,
    KIND_STORE = 2'd2
  } kind_e;

  typedef enum logic [3:0] {
    OP_ACCESS  = 4'd0,
    OP_PRESENT = 4'd1,
    OP_AVAIL   = 4'd2,
    OP_ALLOC   = 4'd3,
    OP_DEALLOC = 4'd4,
    OP_SETPERM = 4'd5,
    OP_LOCK    = 4'd6,
    OP_UNLOCK  = 4'd7,
    OP_TSTLOCK = 4'd8,
    OP_PROBE   = 4'd9
  } op_e;
endpackage

// File: rtl/tag_dir_lookup.sv
module tag_dir_lookup
  import tag_dir_pkg::*;
#(
  parameter int TAG_W = 10,
  parameter int WAYS  = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0][1:0]       perms_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic [WAYS-1:0]            match_vec_o,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           hit_way_o,
  output logic                       free_o,
  output logic [WAY_W-1:0]           free_way_o
);
  always_comb begin
    match_vec_o = '0;
    hit_o       = 1'b0;
    hit_way_o   = '0;
    free_o      = 1'b0;
    free_way_o  = '0;
    // descending scan leaves the lowest qualifying way
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (perms_i[w] != PERM_NONE && tags_i[w] == tag_i) begin
        match_vec_o[w] = 1'b1;
        hit_o          = 1'b1;
        hit_way_o      = WAY_W'(w);
      end
      if (perms_i[w] == PERM_NONE) begin
        free_o     = 1'b1;
        free_way_o = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/tag_dir_lru.sv
module tag_dir_lru #(
  parameter int SETS = 4,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_set_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [IDX_W-1:0] rd_set_i,
  output logic [WAY_W-1:0] victim_o
);
  logic [SETS-1:0][WAY_W-1:0] vict_w;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    // age 0 = most recent, WAYS-1 = victim
    logic [WAYS-1:0][WAY_W-1:0] age_q;
    logic [WAYS-1:0]            oldest;
    logic [WAY_W-1:0]           enc;

    always_comb begin
      enc = '0;
      for (int w = 0; w < WAYS; w++) begin
        oldest[w] = (age_q[w] == WAY_W'(WAYS - 1));
        if (oldest[w]) enc = WAY_W'(w);
      end
    end
    assign vict_w[s] = enc;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int w = 0; w < WAYS; w++) age_q[w] <= WAY_W'(WAYS - 1 - w);
      end else if (touch_i && touch_set_i == IDX_W'(s)) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == touch_way_i) age_q[w] <= '0;
          else if (age_q[w] < age_q[touch_way_i]) age_q[w] <= age_q[w] + 1'b1;
        end
      end
    end

    assert_single_victim_R11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(oldest) == 1)
      else $error("lru set %0d has no unique victim", s);
  end

  assign victim_o = vict_w[rd_set_i];
endmodule

// File: rtl/tag_dir.sv
module tag_dir
  import tag_dir_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CACHE_BYTES = 256,
  parameter int LINE_BYTES  = 16,
  parameter int WAYS        = 4,
  parameter int CTX_W       = 4,
  localparam int WAY_W      = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [3:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_kind_i,
  input  logic [1:0]        req_perm_i,
  input  logic [CTX_W-1:0]  req_ctx_i,
  output logic              rsp_valid_o,
  output logic              rsp_ok_o,
  output logic              rsp_err_o,
  output logic [WAY_W-1:0]  rsp_way_o,
  output logic [ADDR_W-1:0] rsp_addr_o
);
  localparam int SETS  = CACHE_BYTES / WAYS / LINE_BYTES;
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
  logic [SETS-1:0][WAYS-1:0][1:0]       perm_q;
  logic [SETS-1:0][WAYS-1:0][CTX_W-1:0] lock_q;

  op_e              op;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] req_tag;
  logic [WAYS-1:0]  match_vec;
  logic             hit, free, avail, alloc_ok, fire;
  logic [WAY_W-1:0] hit_way, free_way, victim_way;
  logic [1:0]       cur_perm;
  logic [CTX_W-1:0] cur_lock;
  logic             touch;
  logic [WAY_W-1:0] touch_way;

  assign op      = op_e'(req_op_i);
  assign idx     = req_addr_i[OFF_W +: IDX_W];
  assign req_tag = req_addr_i[ADDR_W-1 -: TAG_W];
  assign fire    = req_valid_i;

  tag_dir_lookup #(.TAG_W(TAG_W), .WAYS(WAYS)) i_lookup (
    .tags_i      (tag_q[idx]),
    .perms_i     (perm_q[idx]),
    .tag_i       (req_tag),
    .match_vec_o (match_vec),
    .hit_o       (hit),
    .hit_way_o   (hit_way),
    .free_o      (free),
    .free_way_o  (free_way)
  );

  assign avail    = hit | free;
  assign alloc_ok = !hit && free;
  assign cur_perm = perm_q[idx][hit_way];
  assign cur_lock = lock_q[idx][hit_way];
  assign touch    = fire && ((op == OP_ACCESS && hit) || (op == OP_ALLOC && alloc_ok));
  assign touch_way = (op == OP_ALLOC) ? free_way : hit_way;

  tag_dir_lru #(.SETS(SETS), .WAYS(WAYS)) i_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (touch),
    .touch_set_i (idx),
    .touch_way_i (touch_way),
    .rd_set_i    (idx),
    .victim_o    (victim_way)
  );

  logic              ok_d, err_d;
  logic [WAY_W-1:0]  way_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    ok_d   = 1'b0;
    err_d  = 1'b0;
    way_d  = '0;
    addr_d = '0;
    unique case (op)
      OP_ACCESS, OP_PRESENT: begin
        if (hit) way_d = hit_way;
        if (op == OP_PRESENT) ok_d = hit;
        else ok_d = hit && (cur_perm == PERM_RW ||
                     (cur_perm == PERM_RO && req_kind_i inside {KIND_LOAD, KIND_FETCH}));
      end
      OP_AVAIL: ok_d = avail;
      OP_ALLOC: begin
        ok_d  = alloc_ok;
        err_d = !alloc_ok;
        if (alloc_ok) way_d = free_way;
      end
      OP_DEALLOC, OP_SETPERM, OP_LOCK, OP_UNLOCK, OP_TSTLOCK: begin
        err_d = !hit;
        if (hit) way_d = hit_way;
        ok_d  = hit && (op != OP_TSTLOCK || cur_lock == req_ctx_i);
      end
      OP_PROBE: begin
        ok_d  = !avail;
        err_d = avail;
        if (!avail) begin
          way_d  = victim_way;
          addr_d = {tag_q[idx][victim_way], idx, {OFF_W{1'b0}}};
        end
      end
      default: err_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q  <= '0;
      perm_q <= '0;
      lock_q <= '1;
    end else if (fire) begin
      if (op == OP_ALLOC && alloc_ok) begin
        tag_q[idx][free_way]  <= req_tag;
        perm_q[idx][free_way] <= PERM_INV;
        lock_q[idx][free_way] <= '1;
      end else if (hit) begin
        case (op)
          OP_DEALLOC: begin
            perm_q[idx][hit_way] <= PERM_NONE;
            lock_q[idx][hit_way] <= '1;
          end
          OP_SETPERM: begin
            perm_q[idx][hit_way] <= req_perm_i;
            if (req_perm_i != PERM_RW) lock_q[idx][hit_way] <= '1;
          end
          OP_LOCK:   lock_q[idx][hit_way] <= req_ctx_i;
          OP_UNLOCK: lock_q[idx][hit_way] <= '1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_ok_o    <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_way_o   <= '0;
      rsp_addr_o  <= '0;
    end else begin
      rsp_valid_o <= fire;
      rsp_ok_o    <= fire & ok_d;
      rsp_err_o   <= fire & err_d;
      rsp_way_o   <= fire ? way_d : '0;
      rsp_addr_o  <= fire ? addr_d : '0;
    end
  end

  logic alloc_fire, alloc_bad, demote_fire;
  assign alloc_fire  = fire && op == OP_ALLOC && alloc_ok;
  assign alloc_bad   = fire && op == OP_ALLOC && !alloc_ok;
  assign demote_fire = fire && op == OP_SETPERM && hit && req_perm_i != PERM_RW;

  assert_line_aligned_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> req_addr_i[OFF_W-1:0] == '0)
    else $error("unaligned request address");

  assert_single_match_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> $onehot0(match_vec))
    else $error("tag matches more than one way");

  assert_alloc_init_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_fire |=> perm_q[$past(idx)][$past(free_way)] == PERM_INV &&
                   lock_q[$past(idx)][$past(free_way)] == {CTX_W{1'b1}})
    else $error("allocated way not invalid and unlocked");

  assert_alloc_refused_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_bad |=> $stable(perm_q) && $stable(tag_q) && $stable(lock_q))
    else $error("refused allocation changed state");

  assert_demote_unlock_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    demote_fire |=> lock_q[$past(idx)][$past(hit_way)] == {CTX_W{1'b1}})
    else $error("permission demotion kept lock");
endmodule

// File: tb/test_tag_dir.sv
module test_tag_dir;
  localparam int NS = 4;
  localparam int NW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_op = '0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic [1:0]  req_perm = '0;
  logic [3:0]  req_ctx = '0;
  logic        rsp_valid, rsp_ok, rsp_err;
  logic [1:0]  rsp_way;
  logic [15:0] rsp_addr;

  tag_dir i_tag_dir (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_kind_i(req_kind), .req_perm_i(req_perm),
    .req_ctx_i(req_ctx), .rsp_valid_o(rsp_valid), .rsp_ok_o(rsp_ok),
    .rsp_err_o(rsp_err), .rsp_way_o(rsp_way), .rsp_addr_o(rsp_addr)
  );

  always #5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  int m_tag [NS][NW];
  int m_perm[NS][NW];
  int m_lock[NS][NW];
  int ord   [NS][NW]; // ord[s][0] least recent

  function automatic logic [15:0] mk(int t, int s);
    return {10'(t), 2'(s), 4'b0};
  endfunction

  task automatic check(bit good, string r, string what, logic [20:0] act, logic [20:0] exp);
    n_run++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        m_tag[s][w] = 0; m_perm[s][w] = 0; m_lock[s][w] = 15; ord[s][w] = w;
      end
  endtask

  task automatic touch(int s, int w);
    int p = 0;
    for (int i = 0; i < NW; i++) if (ord[s][i] == w) p = i;
    for (int i = p; i < NW - 1; i++) ord[s][i] = ord[s][i+1];
    ord[s][NW-1] = w;
  endtask

  task automatic model_step(int op, logic [15:0] a, int kind, int perm, int ctx,
                            output logic [20:0] exp);
    int s = int'(a[5:4]);
    int t = int'(a[15:6]);
    bit hit = 0, fr = 0, ok = 0, err = 0;
    int hw = 0, fw = 0, way = 0;
    logic [15:0] va = '0;
    for (int w = 0; w < NW; w++)
      if (m_perm[s][w] != 0 && m_tag[s][w] == t) begin hit = 1; hw = w; end
    for (int w = NW - 1; w >= 0; w--)
      if (m_perm[s][w] == 0) begin fr = 1; fw = w; end
    case (op)
      0: if (hit) begin
           way = hw; touch(s, hw);
           ok = (m_perm[s][hw] == 3) || (m_perm[s][hw] == 2 && kind < 2);
         end
      1: begin ok = hit; if (hit) way = hw; end
      2: ok = hit || fr;
      3: if (!hit && fr) begin
           ok = 1; way = fw; m_tag[s][fw] = t; m_perm[s][fw] = 1; m_lock[s][fw] = 15;
           touch(s, fw);
         end else err = 1;
      4, 5, 6, 7, 8: if (!hit) err = 1;
         else begin
           way = hw; ok = 1;
           case (op)
             4: begin m_perm[s][hw] = 0; m_lock[s][hw] = 15; end
             5: begin m_perm[s][hw] = perm; if (perm != 3) m_lock[s][hw] = 15; end
             6: m_lock[s][hw] = ctx;
             7: m_lock[s][hw] = 15;
             default: ok = (m_lock[s][hw] == ctx);
           endcase
         end
      9: if (!(hit || fr)) begin
           ok = 1; way = ord[s][0]; va = mk(m_tag[s][way], s);
         end else err = 1;
      default: err = 1;
    endcase
    exp = {1'b1, ok, err, 2'(way), va};
  endtask

  task automatic req(int op, logic [15:0] a, int kind, int perm, int ctx, string r);
    logic [20:0] exp;
    req_valid = 1'b1; req_op = 4'(op); req_addr = a;
    req_kind = 2'(kind); req_perm = 2'(perm); req_ctx = 4'(ctx);
    model_step(op, a, kind, perm, ctx, exp);
    @(negedge clk);
    req_valid = 1'b0;
    check({rsp_valid, rsp_ok, rsp_err, rsp_way, rsp_addr} == exp, r,
          $sformatf("op %0d addr %h", op, a), {rsp_valid, rsp_ok, rsp_err, rsp_way, rsp_addr}, exp);
  endtask

  task automatic idle(int n, string r);
    repeat (n) begin
      @(negedge clk);
      check(rsp_valid == 1'b0, r, "idle pulse", 21'(rsp_valid), 21'd0);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R13 reset state, R2 no pulse when idle
    idle(2, "R2");
    req(1, mk(1, 0), 0, 0, 0, "R13");
    req(2, mk(1, 0), 0, 0, 0, "R13");
    req(9, mk(1, 0), 0, 0, 0, "R12");
    // R6 fill set 0 in way order
    for (int t = 1; t <= 4; t++) req(3, mk(t, 0), 0, 0, 0, "R6");
    // R7 full set and duplicate
    req(3, mk(5, 0), 0, 0, 0, "R7");
    req(3, mk(2, 0), 0, 0, 0, "R7");
    req(1, mk(5, 0), 0, 0, 0, "R7");
    // R5 availability
    req(2, mk(5, 0), 0, 0, 0, "R5");
    req(2, mk(3, 0), 0, 0, 0, "R5");
    // R12 victim after fill is way 0
    req(9, mk(5, 0), 0, 0, 0, "R12");
    // R4 permission by kind
    req(5, mk(1, 0), 0, 2, 0, "R10");
    req(0, mk(1, 0), 2, 0, 0, "R4");
    req(0, mk(1, 0), 0, 0, 0, "R4");
    req(0, mk(1, 0), 1, 0, 0, "R4");
    req(0, mk(1, 0), 3, 0, 0, "R4");
    req(5, mk(2, 0), 0, 3, 0, "R10");
    req(0, mk(2, 0), 2, 0, 0, "R4");
    req(0, mk(3, 0), 0, 0, 0, "R4");
    req(0, mk(9, 0), 0, 0, 0, "R3");
    // R11 denied hits also age; probe follows
    req(9, mk(7, 0), 0, 0, 0, "R11");
    // R9 locks
    req(6, mk(2, 0), 0, 0, 5, "R9");
    req(8, mk(2, 0), 0, 0, 5, "R9");
    req(8, mk(2, 0), 0, 0, 4, "R9");
    req(5, mk(2, 0), 0, 3, 0, "R10");
    req(8, mk(2, 0), 0, 0, 5, "R10");
    req(5, mk(2, 0), 0, 2, 0, "R10");
    req(8, mk(2, 0), 0, 0, 5, "R10");
    req(8, mk(2, 0), 0, 0, 15, "R9");
    req(6, mk(1, 0), 0, 0, 7, "R9");
    req(7, mk(1, 0), 0, 0, 0, "R9");
    req(8, mk(1, 0), 0, 0, 7, "R9");
    // R8 deallocation and reuse
    req(6, mk(4, 0), 0, 0, 2, "R8");
    req(4, mk(4, 0), 0, 0, 0, "R8");
    req(1, mk(4, 0), 0, 0, 0, "R8");
    req(8, mk(4, 0), 0, 0, 2, "R8");
    req(4, mk(4, 0), 0, 0, 0, "R8");
    req(3, mk(5, 0), 0, 0, 0, "R6");
    req(8, mk(5, 0), 0, 0, 15, "R6");
    req(9, mk(8, 0), 0, 0, 0, "R11");
    // R1 sets are independent
    req(3, mk(1, 1), 0, 0, 0, "R1");
    req(1, mk(1, 1), 0, 0, 0, "R1");
    req(1, mk(1, 2), 0, 0, 0, "R1");
    req(2, mk(6, 1), 0, 0, 0, "R1");
    // R14 undefined opcodes
    req(12, mk(1, 0), 0, 0, 0, "R14");
    req(15, mk(1, 1), 0, 0, 0, "R14");
    req(1, mk(1, 0), 0, 0, 0, "R14");
    // R3 state 0 through permission change
    req(5, mk(3, 0), 0, 0, 0, "R3");
    req(1, mk(3, 0), 0, 0, 0, "R3");
    idle(1, "R2");
    // R2 random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int op = int'($urandom_range(0, 11));
      if (op == 11) op = 3;
      if ($urandom_range(0, 7) == 0) idle(1, "R2");
      req(op, mk(int'($urandom_range(0, 6)), int'($urandom_range(0, 1))),
          int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
          int'($urandom_range(0, 15)), "R2");
    end
    idle(2, "R2");
    finish_run();
  end
endmodule